// File: doc/BRIEF.md
# Program Status Word Unit

This block holds the processor's live status word. The word carries four condition flags, two interrupt-mask bits, an instruction-set state bit and a five-bit mode field. It also keeps one saved copy of the status word for each privileged register bank. Two things change the live word. The first is an explicit status write issued by a move-to-status instruction. The write carries a four-bit field mask taken from the instruction, and a target select chooses the live word or the saved word of the current mode. The second is a flag update from the ALU after an add or subtract, which sets N, Z, C and V from the result and the two operands.

How far a write reaches depends on the current mode. In user mode only the flags can change. In privileged modes the field mask is decoded in priority order. A configuration input picks the wide (32-bit) or narrow (26-bit) layout. In the narrow layout every bit other than the flags, the two interrupt masks and the low two mode bits is cleared after a live write. The unit raises a one-cycle pulse whenever a write alters the mode field. This lets the bank-swapping logic nearby react to the mode change.

Top module: `psr_unit`

## Requirements
- R1: While reset is active, and after it is released, the live word is 0x000000D3: both interrupt masks (bits 7 and 6) are set and the mode (bits 4:0) is 0x13. Every saved word is 0 and the mode-change pulse is low.
- R2: In a privileged mode, a live write whose mask is exactly 4'b1001 replaces the whole word. Mask bit 0 corresponds to instruction bit 16 and mask bit 3 to instruction bit 19.
- R3: In a privileged mode, a live write whose mask is not 4'b1001 but has bit 0 set replaces only bits 7:0. These are the interrupt masks, the state bit and the mode.
- R4: In a privileged mode, a live write whose mask is not 4'b1001, has bit 0 clear and has bit 3 set replaces only bits 31:28 (N, Z, C, V). Any other mask value leaves the word unchanged.
- R5: In user mode (mode 0x00 or 0x10), a live write replaces only bits 31:28, whatever the mask.
- R6: A saved-status write uses the same mask rules as R2 to R4 and lands in the saved word of the current mode's bank. The banks are modes 0x01/0x11, 0x02/0x12, 0x03/0x13, 0x17 and 0x1B. The write is ignored in user mode and in every mode outside these banks. The `saved_o` port shows the current bank's saved word, or 0 when there is none.
- R7: When `wide_mode` is low, a live write leaves only bits 31:28, 7:6 and 1:0 possibly set. Every other bit is cleared.
- R8: An ALU update sets N to bit 31 of the result and sets Z exactly when the result is zero.
- R9: For an add, C is set when at least two of these hold: a is negative, b is negative, the result is non-negative. V is set when a and b have the same sign and the result has the other sign.
- R10: For a subtract, C (not-borrow) is set when at least two of these hold: a is negative, b is non-negative, the result is non-negative. V is set when the signs of a and b differ and the sign of the result differs from that of a.
- R11: When a live write and an ALU update arrive in the same cycle, only the write takes effect, even if its mask selects no field.
- R12: `mode_chg_o` is high for exactly the cycle after a live write that changed bits 4:0. It stays low after a write that leaves the mode as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: wide layout; 0: narrow layout clears the non-kept bits on live writes |
| wr_en | input | 1 | Status write strobe |
| wr_saved | input | 1 | Write target: 0 live word, 1 saved word of current bank |
| wr_mask | input | 4 | Field mask, instruction bits 19:16 |
| wr_data | input | 32 | Value to write |
| alu_en | input | 1 | Apply ALU flags this cycle |
| alu_sub | input | 1 | 0 add, 1 subtract |
| alu_a | input | 32 | First operand |
| alu_b | input | 32 | Second operand |
| alu_res | input | 32 | ALU result |
| status_o | output | 32 | Live status word |
| saved_o | output | 32 | Saved word of the current bank, 0 if none |
| mode_chg_o | output | 1 | One-cycle mode-change pulse |

## Verification
The ALU update is tried with operand pairs that sit on the signed and unsigned boundaries. One pair gives a signed overflow without a carry, one a carry with a zero result, one both carry and overflow, and one a subtract that borrows. Each pair therefore separates the carry rule from the overflow rule and the add path from the subtract path. Writes are issued with the masks 1001, 1111, 1000 and 0110, which show whether the priority order is kept rather than merely whether each field is decoded. The same write values are then repeated in user mode and in the narrow layout, where a correct unit must drop most of the bits. Saved writes are aimed at a bankless mode and then read back after returning to supervisor mode, so a write that should have been ignored would become visible.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned MODE_W  = 5;
  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned N_SAVED = 5;

  localparam int unsigned BIT_N = WORD_W - 1;
  localparam int unsigned BIT_Z = WORD_W - 2;
  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_F = 6;

  localparam logic [WORD_W-1:0] FLAG_FIELD   = 32'hF000_0000;
  localparam logic [WORD_W-1:0] CTRL_FIELD   = 32'h0000_00FF;
  localparam logic [WORD_W-1:0] NARROW_KEEP  = 32'hF000_00C3;
  localparam logic [3:0]        MASK_WHOLE   = 4'b1001;

  typedef enum logic [2:0] {
    BK_USER = 3'd0,
    BK_FIQ  = 3'd1,
    BK_IRQ  = 3'd2,
    BK_SVC  = 3'd3,
    BK_ABT  = 3'd4,
    BK_UND  = 3'd5,
    BK_NONE = 3'd6
  } bank_e;

  typedef enum logic [1:0] {
    SC_NONE  = 2'd0,
    SC_WHOLE = 2'd1,
    SC_CTRL  = 2'd2,
    SC_FLAGS = 2'd3
  } scope_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      5'h00, 5'h10: return BK_USER;
      5'h01, 5'h11: return BK_FIQ;
      5'h02, 5'h12: return BK_IRQ;
      5'h03, 5'h13: return BK_SVC;
      5'h17:        return BK_ABT;
      5'h1B:        return BK_UND;
      default:      return BK_NONE;
    endcase
  endfunction

  function automatic scope_e scope_of(input logic [3:0] mask, input logic user);
    if (user)                    return SC_FLAGS;
    else if (mask == MASK_WHOLE) return SC_WHOLE;
    else if (mask[0])            return SC_CTRL;
    else if (mask[3])            return SC_FLAGS;
    else                         return SC_NONE;
  endfunction

  function automatic logic [WORD_W-1:0] scope_bits(input scope_e s);
    case (s)
      SC_WHOLE: return '1;
      SC_CTRL:  return CTRL_FIELD;
      SC_FLAGS: return FLAG_FIELD;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old_w,
                                              input logic [WORD_W-1:0] new_w,
                                              input logic [WORD_W-1:0] sel);
    return (old_w & ~sel) | (new_w & sel);
  endfunction

  function automatic logic majority3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic nzcv_t alu_flags(input logic sub, input logic a_neg,
                                      input logic b_neg, input logic r_neg,
                                      input logic r_zero);
    nzcv_t f;
    f.n = r_neg;
    f.z = r_zero;
    if (sub) begin
      f.c = majority3(a_neg, ~b_neg, ~r_neg);
      f.v = (a_neg != b_neg) && (r_neg != a_neg);
    end else begin
      f.c = majority3(a_neg, b_neg, ~r_neg);
      f.v = (a_neg == b_neg) && (r_neg != a_neg);
    end
    return f;
  endfunction

endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
(
  input  logic              sub,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] r,
  output nzcv_t             flags,
  output logic              wide_c,
  output logic              res_ok
);

  logic [WORD_W:0] ext_sum;
  logic [WORD_W:0] ext_dif;

  assign ext_sum = {1'b0, a} + {1'b0, b};
  assign ext_dif = {1'b0, a} - {1'b0, b};

  assign flags  = alu_flags(sub, a[WORD_W-1], b[WORD_W-1], r[WORD_W-1], r == '0);
  assign wide_c = sub ? ~ext_dif[WORD_W] : ext_sum[WORD_W];
  assign res_ok = sub ? (ext_dif[WORD_W-1:0] == r) : (ext_sum[WORD_W-1:0] == r);

endmodule

// File: rtl/psr_live_reg.sv
module psr_live_reg
  import psr_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = 5'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              wr_fire,
  input  logic [3:0]        wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              alu_en,
  input  nzcv_t             alu_nzcv,
  output logic [WORD_W-1:0] status_q,
  output logic              mode_chg_q,
  output bank_e             cur_bank
);

  localparam logic [WORD_W-1:0] RESET_WORD =
    (WORD_W'(1) << BIT_I) | (WORD_W'(1) << BIT_F) | WORD_W'(RESET_MODE);

  logic              in_user;
  scope_e            wr_scope;
  logic [WORD_W-1:0] wr_sel;
  logic [WORD_W-1:0] wr_merged;
  logic [WORD_W-1:0] wr_next;
  logic [WORD_W-1:0] alu_next;
  logic [WORD_W-1:0] status_d;
  logic              mode_alters;

  assign cur_bank  = bank_of(status_q[MODE_W-1:0]);
  assign in_user   = (cur_bank == BK_USER);
  assign wr_scope  = scope_of(wr_mask, in_user);
  assign wr_sel    = scope_bits(wr_scope);
  assign wr_merged = merge(status_q, wr_data, wr_sel);
  assign wr_next   = wide_mode ? wr_merged : (wr_merged & NARROW_KEEP);
  assign alu_next  = {alu_nzcv, status_q[WORD_W-FLAG_W-1:0]};

  always_comb begin
    if (wr_fire)     status_d = wr_next;
    else if (alu_en) status_d = alu_next;
    else             status_d = status_q;
  end

  assign mode_alters = wr_fire && (wr_next[MODE_W-1:0] != status_q[MODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= RESET_WORD;
      mode_chg_q <= 1'b0;
    end else begin
      status_q   <= status_d;
      mode_chg_q <= mode_alters;
    end
  end

  AST_USER_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && in_user) |=> (status_q[WORD_W-FLAG_W-1:0] == $past(status_q[WORD_W-FLAG_W-1:0]))); // R5

  AST_NARROW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wide_mode) |=> ((status_q & ~NARROW_KEEP) == '0)); // R7

  AST_WRITE_BEATS_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && alu_en && wide_mode && wr_scope == SC_NONE) |=> $stable(status_q)); // R11

  AST_PULSE_MEANS_MODE_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_q |-> (status_q[MODE_W-1:0] != $past(status_q[MODE_W-1:0]))); // R12

endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             cur_bank,
  input  logic              wr_fire,
  input  logic [3:0]        wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] saved_o
);

  logic [WORD_W-1:0] words [N_SAVED];
  logic [WORD_W-1:0] sel;
  logic              has_slot;

  assign sel      = scope_bits(scope_of(wr_mask, 1'b0));
  assign has_slot = (cur_bank != BK_USER) && (cur_bank != BK_NONE);

  for (genvar g = 0; g < N_SAVED; g++) begin : g_slot
    localparam bank_e MY_BANK = bank_e'(g + 1);
    always_ff @(posedge clk) begin
      if (!rst_n)                               words[g] <= '0;
      else if (wr_fire && cur_bank == MY_BANK)  words[g] <= merge(words[g], wr_data, sel);
    end
  end

  always_comb begin
    saved_o = '0;
    for (int k = 0; k < N_SAVED; k++) begin
      if (cur_bank == bank_e'(k + 1)) saved_o = words[k];
    end
  end

  AST_SAVED_IGNORED_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !has_slot) |=> (words[0] == $past(words[0]) && words[1] == $past(words[1]) &&
                                 words[2] == $past(words[2]) && words[3] == $past(words[3]) &&
                                 words[4] == $past(words[4]))); // R6

endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter logic [4:0] RESET_MODE = 5'h13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_mode,
  input  logic        wr_en,
  input  logic        wr_saved,
  input  logic [3:0]  wr_mask,
  input  logic [31:0] wr_data,
  input  logic        alu_en,
  input  logic        alu_sub,
  input  logic [31:0] alu_a,
  input  logic [31:0] alu_b,
  input  logic [31:0] alu_res,
  output logic [31:0] status_o,
  output logic [31:0] saved_o,
  output logic        mode_chg_o
);

  logic  live_wr;
  logic  saved_wr;
  nzcv_t nzcv;
  logic  wide_c;
  logic  res_ok;
  bank_e cur_bank;

  assign live_wr  = wr_en & ~wr_saved;
  assign saved_wr = wr_en &  wr_saved;

  psr_flag_calc u_flags (
    .sub    (alu_sub),
    .a      (alu_a),
    .b      (alu_b),
    .r      (alu_res),
    .flags  (nzcv),
    .wide_c (wide_c),
    .res_ok (res_ok)
  );

  psr_live_reg #(.RESET_MODE(RESET_MODE)) u_live (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_mode  (wide_mode),
    .wr_fire    (live_wr),
    .wr_mask    (wr_mask),
    .wr_data    (wr_data),
    .alu_en     (alu_en),
    .alu_nzcv   (nzcv),
    .status_q   (status_o),
    .mode_chg_q (mode_chg_o),
    .cur_bank   (cur_bank)
  );

  psr_saved_bank u_saved (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_bank (cur_bank),
    .wr_fire  (saved_wr),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .saved_o  (saved_o)
  );

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !live_wr) |=> (status_o[BIT_Z] == ($past(alu_res) == '0))); // R8

  AST_CARRY_MATCHES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && res_ok) |-> (nzcv.c == wide_c)); // R9 R10

endmodule

// File: tb/psr_unit_tb_top.sv
`timescale 1ns/1ps
module psr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b1;
  logic        wr_en = 1'b0, wr_saved = 1'b0;
  logic [3:0]  wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic        alu_en = 1'b0, alu_sub = 1'b0;
  logic [31:0] alu_a = '0, alu_b = '0, alu_res = '0;
  logic [31:0] status_o, saved_o;
  logic        mode_chg_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  psr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .wr_en(wr_en), .wr_saved(wr_saved),
    .wr_mask(wr_mask), .wr_data(wr_data), .alu_en(alu_en), .alu_sub(alu_sub),
    .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
    .status_o(status_o), .saved_o(saved_o), .mode_chg_o(mode_chg_o)
  );

  typedef struct {
    logic [31:0] st;
    logic [31:0] sv;
    logic        pl;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_st;
  logic [31:0] m_sv [1:5];

  function automatic int slot_of(logic [4:0] m);
    case (m)
      5'd0, 5'd16: return 0;
      5'd1, 5'd17: return 1;
      5'd2, 5'd18: return 2;
      5'd3, 5'd19: return 3;
      5'd23:       return 4;
      5'd27:       return 5;
      default:     return 6;
    endcase
  endfunction

  function automatic logic [31:0] reach(logic [3:0] k, bit usr);
    if (usr) return 32'hF000_0000;
    if (k == 4'b1001) return 32'hFFFF_FFFF;
    if (k[0]) return 32'h0000_00FF;
    if (k[3]) return 32'hF000_0000;
    return 32'h0;
  endfunction

  task automatic step(bit we, bit sav, logic [3:0] k, logic [31:0] d, bit alu, bit sub,
                      logic [31:0] a, logic [31:0] b, bit wide, string tag);
    exp_t e;
    logic [31:0] f, nst, r;
    logic [32:0] wide_sum;
    int s;
    bit pl = 0;
    r = sub ? a - b : a + b;
    s = slot_of(m_st[4:0]);
    if (we && !sav) begin
      f   = reach(k, s == 0);
      nst = (m_st & ~f) | (d & f);
      if (!wide) nst = nst & 32'hF000_00C3;
      pl   = (nst[4:0] != m_st[4:0]);
      m_st = nst;
    end else begin
      if (we && sav && s >= 1 && s <= 5) begin
        f = reach(k, 1'b0);
        m_sv[s] = (m_sv[s] & ~f) | (d & f);
      end
      if (alu) begin
        m_st[31] = r[31];
        m_st[30] = (r == 0);
        if (sub) begin
          m_st[29] = (a >= b);
          wide_sum = {a[31], a} - {b[31], b};
        end else begin
          wide_sum = {1'b0, a} + {1'b0, b};
          m_st[29] = wide_sum[32];
          wide_sum = {a[31], a} + {b[31], b};
        end
        m_st[28] = (wide_sum[32] != wide_sum[31]);
      end
    end
    @(negedge clk);
    wr_en = we; wr_saved = sav; wr_mask = k; wr_data = d;
    alu_en = alu; alu_sub = sub; alu_a = a; alu_b = b; alu_res = r; wide_mode = wide;
    e.st = m_st;
    s = slot_of(m_st[4:0]);
    e.sv = (s >= 1 && s <= 5) ? m_sv[s] : 32'h0;
    e.pl = pl;
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic wr(logic [3:0] k, logic [31:0] d, bit sav, string tag);
    step(1, sav, k, d, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic alu(bit sub, logic [31:0] a, logic [31:0] b, string tag);
    step(0, 0, 4'h0, 0, 1, sub, a, b, 1, tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 4'h0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_tests++;
      if (status_o !== e.st || saved_o !== e.sv || mode_chg_o !== e.pl) begin
        n_fail++;
        $display("FAIL %s: status=%h saved=%h pulse=%b expected status=%h saved=%h pulse=%b",
                 e.tag, status_o, saved_o, mode_chg_o, e.st, e.sv, e.pl);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_st = 32'h0000_00D3;
    for (int i = 1; i <= 5; i++) m_sv[i] = 32'h0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (status_o !== 32'h0000_00D3 || saved_o !== 32'h0 || mode_chg_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: status=%h saved=%h pulse=%b expected status=000000d3 saved=0 pulse=0",
               status_o, saved_o, mode_chg_o);
    end
    rst_n = 1'b1;
    idle("R1 after release");

    wr(4'b1001, 32'h8000_00D1, 0, "R2 whole word, R12 pulse");
    idle("R12 pulse drops");
    wr(4'b1111, 32'h0F0F_0F93, 0, "R3 ctrl only wins over flags");
    wr(4'b1000, 32'h5000_0000, 0, "R4 flags only");
    wr(4'b1000, 32'h5A00_0093, 0, "R12 no pulse when mode kept");
    wr(4'b0110, 32'hFFFF_FFFF, 0, "R4 no field selected");

    wr(4'b1001, 32'h1234_5678, 1, "R6 saved write in svc");
    wr(4'b0001, 32'h0000_00D4, 0, "R6 move to bankless mode");
    wr(4'b1001, 32'hDEAD_BEEF, 1, "R6 saved write ignored in bankless mode");
    wr(4'b0001, 32'h0000_00D3, 0, "R6 back to svc, saved intact");
    wr(4'b1000, 32'hA000_0000, 1, "R6 saved flags-only write");

    alu(0, 32'h7FFF_FFFF, 32'h1, "R9 add overflow no carry, R8 N");
    alu(0, 32'hFFFF_FFFF, 32'h1, "R9 add carry, R8 Z");
    alu(0, 32'h8000_0000, 32'h8000_0000, "R9 add carry and overflow");
    alu(1, 32'h5, 32'h5, "R10 sub equal no borrow, R8 Z");
    alu(1, 32'h3, 32'h5, "R10 sub borrow, R8 N");
    alu(1, 32'h8000_0000, 32'h1, "R10 sub overflow");

    step(1, 0, 4'b0000, 32'h0, 1, 0, 32'h0, 32'h0, 1, "R11 empty write blocks ALU");
    step(1, 0, 4'b1000, 32'h1000_0000, 1, 1, 32'h3, 32'h5, 1, "R11 write flags beat ALU");

    step(1, 0, 4'b1001, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R7 narrow layout clears bits");
    idle("R7 narrow state held");
    step(1, 0, 4'b0001, 32'h0000_00F3, 0, 0, 0, 0, 1, "R7 leave narrow, R3 ctrl");

    wr(4'b1001, 32'h0000_00D0, 0, "R5 enter user mode");
    wr(4'b1001, 32'hA000_00DF, 0, "R5 whole mask limited to flags");
    wr(4'b0001, 32'h5000_0013, 0, "R5 ctrl mask still flags only");
    wr(4'b1001, 32'h1111_1111, 1, "R6 saved write ignored in user mode");
    alu(1, 32'h0, 32'h1, "R10 sub borrow in user mode");
    idle("final");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule